// File: doc/BRIEF.md
# Protected Indexed Register Write Unit

This block holds a small bank of reset-management registers (stack limit, system guard, system control, stop/wait) and guards them against stray writes. Software can read any of them at its page-0 address at any time. A write takes effect only through a two-step sequence. First, software writes the target register's page-0 address, used as an index, to an index port. Then it writes the new value to a data port.

Between the two steps the block watches every bus cycle. Instruction prefetches, which are ROM-area reads, may fall between the steps without effect. Any other bus access silently cancels the pending sequence, and no register changes. The register contents are also brought out as a flat vector for the logic that acts on them.

Top module: `prot_reg_unit`

## Requirements
- R1: On reset (asynchronous assertion of `rst_n` low), every protected register takes its default value, which is 0 with the default parameters, and the sequence returns to idle. The internal release follows two clock edges after `rst_n` rises.
- R2: While `bus_rd` is high and `bus_addr` equals a protected register's address, `bus_rdata` shows that register combinationally. The addresses are 0x0005 to 0x0008 for registers 0 to 3. Any other read address, or no read, gives 0 on `bus_rdata`.
- R3: A cycle with `bus_wr`=1, `bus_rom`=0 and `bus_addr`=0x003E is an index write. It arms the sequence and stores `bus_wdata` as the index.
- R4: When the sequence is armed, a cycle with `bus_wr`=1, `bus_rom`=0 and `bus_addr`=0x003F writes `bus_wdata` into the register whose address equals the index. The new value is visible from the next cycle, and the sequence returns to idle.
- R5: While the sequence is armed, ROM reads leave it armed. A ROM read has `bus_rd`=1, `bus_rom`=1 and `bus_wr`=0. Cycles with neither `bus_rd` nor `bus_wr` also leave it armed.
- R6: While the sequence is armed, any other cycle with `bus_rd` or `bus_wr` high cancels it. This includes a non-ROM read, a write to another address, and a write with `bus_rom`=1, even one to 0x003F. No register changes, and a later data-port write has no effect.
- R7: A data-port write while the sequence is idle changes no register. This covers a second data write after a commit.
- R8: An index write while the sequence is armed re-arms it with the new index. Only the register named by the latest index is updated.
- R9: An index that matches no protected register arms the sequence, but the following data write changes nothing and returns the sequence to idle.
- R10: `reg_contents` shows register i in bits [8i+7:8i] at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Bus address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_rom | input | 1 | Cycle targets the ROM area |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for protected registers |
| reg_contents | output | 32 | All protected registers, register i in bits [8i+7:8i] |

## Verification
The update path is tried four ways: a clean back-to-back index and data pair to each register, a pair with ROM reads and idle cycles between the steps, a pair broken by each kind of intruding cycle, and pairs whose index is replaced or matches nothing. A clean pair shows that the right register is selected. The separated pair distinguishes tolerated cycles from aborting ones. Each intruder kind (non-ROM read, RAM write, ROM write to the data port) checks one branch of the abort decision separately. Data writes with no armed index, and a reset in the middle of a sequence, confirm that nothing reaches the bank without a fresh index.

// File: rtl/prot_reg_pkg.sv
package prot_reg_pkg;

  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_ARMED = 1'b1
  } seq_state_e;

  typedef struct packed {
    logic idx_wr;
    logic dat_wr;
    logic rom_rd;
    logic any;
  } bus_class_t;

endpackage

// File: rtl/prot_rst_sync.sv
module prot_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end

endmodule

// File: rtl/prot_seq_ctrl.sv
module prot_seq_ctrl
  import prot_reg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_class_t        cls,
  input  logic [DATA_W-1:0] wdata,
  output logic              armed,
  output logic              commit_en,
  output logic [DATA_W-1:0] commit_idx
);

  seq_state_e        state_q, state_d;
  logic [DATA_W-1:0] idx_q;
  logic              idx_en;

  // next-state decision
  always_comb begin
    state_d   = state_q;
    idx_en    = 1'b0;
    commit_en = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (cls.idx_wr) begin
          state_d = SEQ_ARMED;
          idx_en  = 1'b1;
        end
      end
      SEQ_ARMED: begin
        if (cls.idx_wr) begin
          idx_en = 1'b1;
        end else if (cls.dat_wr) begin
          commit_en = 1'b1;
          state_d   = SEQ_IDLE;
        end else if (cls.rom_rd) begin
          state_d = SEQ_ARMED;
        end else if (cls.any) begin
          state_d = SEQ_IDLE;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= wdata;
    end
  end

  assign armed      = (state_q == SEQ_ARMED);
  assign commit_idx = idx_q;

endmodule

// File: rtl/prot_reg_bank.sv
module prot_reg_bank #(
  parameter int                           ADDR_W    = 16,
  parameter int                           DATA_W    = 8,
  parameter int                           NUM_REGS  = 4,
  parameter logic [ADDR_W-1:0]            BASE_ADDR = 'h0005,
  parameter logic [NUM_REGS*DATA_W-1:0]   RST_VALS  = '0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         commit_en,
  input  logic [DATA_W-1:0]            commit_idx,
  input  logic [DATA_W-1:0]            wdata,
  output logic [NUM_REGS*DATA_W-1:0]   regs_flat
);

  logic [ADDR_W-1:0] idx_addr;

  assign idx_addr = ADDR_W'(commit_idx);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [ADDR_W-1:0] MY_ADDR = BASE_ADDR + ADDR_W'(i);
    logic              hit;
    logic [DATA_W-1:0] val_q;

    assign hit = commit_en && (idx_addr == MY_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= RST_VALS[i*DATA_W +: DATA_W];
      end else if (hit) begin
        val_q <= wdata;
      end
    end

    assign regs_flat[i*DATA_W +: DATA_W] = val_q;
  end

endmodule

// File: rtl/prot_rd_mux.sv
module prot_rd_mux #(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 8,
  parameter int                NUM_REGS  = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h0005
) (
  input  logic                        bus_rd,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [NUM_REGS*DATA_W-1:0]  regs_flat,
  output logic [DATA_W-1:0]           rdata
);

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (bus_rd && (bus_addr == BASE_ADDR + ADDR_W'(i))) begin
        rdata = regs_flat[i*DATA_W +: DATA_W];
      end
    end
  end

endmodule

// File: rtl/prot_reg_unit.sv
module prot_reg_unit
  import prot_reg_pkg::*;
#(
  parameter int                          ADDR_W    = 16,
  parameter int                          DATA_W    = 8,
  parameter int                          NUM_REGS  = 4,
  parameter logic [ADDR_W-1:0]           BASE_ADDR = 'h0005,
  parameter logic [ADDR_W-1:0]           IDX_PORT  = 'h003E,
  parameter logic [ADDR_W-1:0]           DAT_PORT  = 'h003F,
  parameter logic [NUM_REGS*DATA_W-1:0]  RST_VALS  = '0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_rd,
  input  logic                        bus_wr,
  input  logic                        bus_rom,
  input  logic [DATA_W-1:0]           bus_wdata,
  output logic [DATA_W-1:0]           bus_rdata,
  output logic [NUM_REGS*DATA_W-1:0]  reg_contents
);

  logic              rst_sync_n;
  bus_class_t        cls;
  logic              armed;
  logic              commit_en;
  logic [DATA_W-1:0] commit_idx;

  prot_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  // classify the current bus cycle
  always_comb begin
    cls.idx_wr = bus_wr && !bus_rom && (bus_addr == IDX_PORT);
    cls.dat_wr = bus_wr && !bus_rom && (bus_addr == DAT_PORT);
    cls.rom_rd = bus_rd && !bus_wr && bus_rom;
    cls.any    = bus_rd || bus_wr;
  end

  prot_seq_ctrl #(.DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cls       (cls),
    .wdata     (bus_wdata),
    .armed     (armed),
    .commit_en (commit_en),
    .commit_idx(commit_idx)
  );

  prot_reg_bank #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .BASE_ADDR(BASE_ADDR),
    .RST_VALS (RST_VALS)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .commit_en (commit_en),
    .commit_idx(commit_idx),
    .wdata     (bus_wdata),
    .regs_flat (reg_contents)
  );

  prot_rd_mux #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .BASE_ADDR(BASE_ADDR)
  ) u_rd (
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .regs_flat(reg_contents),
    .rdata    (bus_rdata)
  );

endmodule

// File: rtl/prot_reg_unit_chk.sv
module prot_reg_unit_chk #(
  parameter int                ADDR_W   = 16,
  parameter int                DATA_W   = 8,
  parameter int                NUM_REGS = 4,
  parameter logic [ADDR_W-1:0] IDX_PORT = 'h003E,
  parameter logic [ADDR_W-1:0] DAT_PORT = 'h003F
) (
  input logic                       clk,
  input logic                       rst_int_n,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic                       bus_rd,
  input logic                       bus_wr,
  input logic                       bus_rom,
  input logic                       armed,
  input logic                       commit_en,
  input logic [NUM_REGS*DATA_W-1:0] reg_contents
);

  logic is_idx, is_dat, is_romrd, is_acc;

  assign is_idx   = bus_wr && !bus_rom && (bus_addr == IDX_PORT);
  assign is_dat   = bus_wr && !bus_rom && (bus_addr == DAT_PORT);
  assign is_romrd = bus_rd && !bus_wr && bus_rom;
  assign is_acc   = bus_rd || bus_wr;

  a_r3_index_arms: assert property (@(posedge clk) disable iff (!rst_int_n)
    is_idx |=> armed);

  a_r4_commit_ends: assert property (@(posedge clk) disable iff (!rst_int_n)
    (armed && is_dat) |=> !armed);

  a_r5_rom_read_holds: assert property (@(posedge clk) disable iff (!rst_int_n)
    (armed && is_romrd) |=> armed);

  a_r6_other_aborts: assert property (@(posedge clk) disable iff (!rst_int_n)
    (armed && is_acc && !is_romrd && !is_idx && !is_dat) |=> (!armed && $stable(reg_contents)));

  a_r7_idle_data_ignored: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!armed && is_dat) |=> $stable(reg_contents));

  a_r6_no_commit_stable: assert property (@(posedge clk) disable iff (!rst_int_n)
    !commit_en |=> $stable(reg_contents));

endmodule

bind prot_reg_unit prot_reg_unit_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .NUM_REGS(NUM_REGS),
  .IDX_PORT(IDX_PORT),
  .DAT_PORT(DAT_PORT)
) u_chk (
  .clk         (clk),
  .rst_int_n   (rst_sync_n),
  .bus_addr    (bus_addr),
  .bus_rd      (bus_rd),
  .bus_wr      (bus_wr),
  .bus_rom     (bus_rom),
  .armed       (armed),
  .commit_en   (commit_en),
  .reg_contents(reg_contents)
);

// File: tb/tb_prot_reg_unit.sv
module tb_prot_reg_unit;

  localparam logic [15:0] IDX = 16'h003E;
  localparam logic [15:0] DAT = 16'h003F;

  logic        clk;
  logic        rst_n;
  logic [15:0] bus_addr;
  logic        bus_rd, bus_wr, bus_rom;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [31:0] reg_contents;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;
  logic [7:0] exp_r [4];

  prot_reg_unit dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_rom(bus_rom), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .reg_contents(reg_contents)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one bus cycle, sampled at the next rising edge
  task automatic bus(input logic [15:0] a, input logic rd, input logic wr, input logic rom, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = rd; bus_wr = wr; bus_rom = rom; bus_wdata = d;
    @(posedge clk);
    #1;
    bus_rd = 1'b0; bus_wr = 1'b0; bus_rom = 1'b0;
  endtask

  task automatic idle_cyc();
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  // compares exposed vector and direct reads (R2, R10); read strobe dropped before the edge
  task automatic check_all(input string req);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(reg_contents[i*8 +: 8] == exp_r[i], {req, " R10 vector"}, 32'(reg_contents[i*8 +: 8]), 32'(exp_r[i]));
      bus_addr = 16'h0005 + 16'(i); bus_rd = 1'b1; bus_rom = 1'b0;
      #1;
      check(bus_rdata == exp_r[i], {req, " R2 read"}, 32'(bus_rdata), 32'(exp_r[i]));
      bus_rd = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    bus_rd = 1'b0; bus_wr = 1'b0; bus_rom = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 4; i++) exp_r[i] = 8'h00;
  endtask

  task automatic t_reset();
    do_reset();
    check_all("R1");
    // unmapped address reads as zero
    @(negedge clk);
    bus_addr = 16'h0004; bus_rd = 1'b1; #1;
    check(bus_rdata == 8'h00, "R2 unmapped", 32'(bus_rdata), 32'h0);
    bus_addr = 16'h0009; #1;
    check(bus_rdata == 8'h00, "R2 unmapped", 32'(bus_rdata), 32'h0);
    bus_rd = 1'b0;
  endtask

  task automatic t_basic();
    for (int i = 0; i < 4; i++) begin
      bus(IDX, 0, 1, 0, 8'h05 + 8'(i));
      bus(DAT, 0, 1, 0, 8'hA0 + 8'(i) * 8'h11);
      exp_r[i] = 8'hA0 + 8'(i) * 8'h11;
    end
    check_all("R3 R4");
  endtask

  task automatic t_rom_between();
    bus(IDX, 0, 1, 0, 8'h06);
    bus(16'h1200, 1, 0, 1, 8'h00);
    idle_cyc();
    bus(16'h1202, 1, 0, 1, 8'h00);
    idle_cyc();
    bus(16'h1204, 1, 0, 1, 8'h00);
    bus(DAT, 0, 1, 0, 8'h3C);
    exp_r[1] = 8'h3C;
    check_all("R5");
  endtask

  task automatic t_abort();
    // non-ROM read between
    bus(IDX, 0, 1, 0, 8'h07);
    bus(16'h0010, 1, 0, 0, 8'h00);
    bus(DAT, 0, 1, 0, 8'h11);
    check_all("R6 ram read");
    // RAM write between
    bus(IDX, 0, 1, 0, 8'h07);
    bus(16'h0020, 0, 1, 0, 8'h55);
    bus(DAT, 0, 1, 0, 8'h22);
    check_all("R6 ram write");
    // ROM write at data port
    bus(IDX, 0, 1, 0, 8'h07);
    bus(DAT, 0, 1, 1, 8'h33);
    bus(DAT, 0, 1, 0, 8'h44);
    check_all("R6 rom write");
    // direct read of a protected register, non-ROM
    bus(IDX, 0, 1, 0, 8'h08);
    bus(16'h0005, 1, 0, 0, 8'h00);
    bus(DAT, 0, 1, 0, 8'h66);
    check_all("R6 reg read");
  endtask

  task automatic t_no_index();
    bus(DAT, 0, 1, 0, 8'hE1);
    check_all("R7 idle");
    bus(IDX, 0, 1, 0, 8'h05);
    bus(DAT, 0, 1, 0, 8'h5A);
    exp_r[0] = 8'h5A;
    bus(DAT, 0, 1, 0, 8'hE2);
    check_all("R7 after commit");
  endtask

  task automatic t_rearm();
    bus(IDX, 0, 1, 0, 8'h05);
    bus(IDX, 0, 1, 0, 8'h08);
    bus(DAT, 0, 1, 0, 8'h77);
    exp_r[3] = 8'h77;
    check_all("R8");
  endtask

  task automatic t_bad_index();
    bus(IDX, 0, 1, 0, 8'h20);
    bus(DAT, 0, 1, 0, 8'h99);
    bus(DAT, 0, 1, 0, 8'h98);
    check_all("R9");
  endtask

  task automatic t_reset_mid();
    bus(IDX, 0, 1, 0, 8'h06);
    do_reset();
    bus(DAT, 0, 1, 0, 8'hCD);
    check_all("R1 mid-sequence");
  endtask

  initial begin
    rst_n = 1'b0;
    bus_addr = '0; bus_rd = 1'b0; bus_wr = 1'b0; bus_rom = 1'b0; bus_wdata = '0;
    t_reset();
    t_basic();
    t_rom_between();
    t_abort();
    t_no_index();
    t_rearm();
    t_bad_index();
    t_basic();
    t_reset_mid();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule